// File: doc/BRIEF.md
# Clock-Generator Configuration Register Slave on I2C

This block is an I2C target that holds the configuration bytes of a clock generator and drives them out as a flat parallel bus. It does not use the bus clock as a clock. It samples SCL and SDA with a fast system clock and finds START, STOP and the SCL edges from the sampled lines. It answers on SDA only by pulling the line low.

A host configures the block with a block write. After the write address, the host sends a command byte and a byte-count byte. The block acknowledges both and discards them. The data bytes that follow fill the registers in ascending order, starting at register 0. The host may end the transfer with STOP after any whole byte.

A block read returns the byte count first. The register bytes follow, lowest register first and most significant bit first. Two bits cannot be written: one reserved bit that always reads zero, and one bit that reports an external strap pin.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The block acknowledges only the 7-bit address 0x69, which is the byte 0xD2 for a write and 0xD3 for a read. For any other address it leaves SDA released until the next START, and no register changes.
- R2: In a write, the block acknowledges the first two bytes after the address (command and byte count) and discards them. Sending only those two bytes changes no register.
- R3: In a write, the third and later bytes go to register 0, register 1 and so on in ascending order, and each one is acknowledged.
- R4: A STOP after any whole byte keeps every byte already received. A byte cut short by STOP is discarded.
- R5: A data byte beyond register 6 gets no acknowledge and is not stored.
- R6: A read returns the value 7 first, then registers 0 to 6, each byte MSB first. The block moves on after a host ACK and releases the bus after a host NACK.
- R7: After reset the registers hold these values: register 0 = 0x00, register 1 = 0xFE, register 2 = 0xFE (with bit 1 showing the strap), register 3 = 0xFE, register 4 = 0x00, register 5 = 0x00, register 6 = 0x06.
- R8: Register 0 bit 3 always reads 0. Register 2 bit 1 always reads `strapIn`. Writes to either bit have no effect.
- R9: A repeated START resets the protocol state and the byte pointer. The data of the next write lands in register 0 again.
- R10: SDA as driven by the block changes only while the sampled SCL is low.
- R11: Register i appears on `cfgRegs[8*i+7:8*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | I2C clock line as seen at the pin |
| sdaIn | input | 1 | I2C data line as seen at the pin |
| strapIn | input | 1 | Strap level that register 2 bit 1 reports |
| sdaOeLow | output | 1 | 1 pulls SDA low; 0 releases it |
| cfgRegs | output | 56 | All registers; register i at bits 8*i+7:8*i |

## Verification
A bad byte pointer shows up as a stored byte in the wrong register on `cfgRegs`. This is visible right after the ACK clock of that byte. It also shows up as a wrong read-back byte, or as an ACK where a NACK is expected, within one byte time. A protocol state that drifts out of step with SCL shows up at the ninth clock of the same byte. The symptoms are a missing or extra ACK, or SDA moving while SCL is high. A masking error on the protected bits shows at once as a nonzero reserved bit, or as a strap bit that does not follow `strapIn`.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } busState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrPtr;
    logic shiftIn;
    logic commitByte;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

  localparam int STRAP_BYTE = 2;
  localparam int STRAP_BIT  = 1;

  function automatic logic [7:0] resetValue(input int idx);
    case (idx)
      1, 2, 3: resetValue = 8'hFE;
      6:       resetValue = 8'h06;
      default: resetValue = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] writableMask(input int idx);
    case (idx)
      0:       writableMask = 8'hF7;
      2:       writableMask = 8'hFD;
      default: writableMask = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] sclPipe;
  logic [PIPE_W-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[PIPE_W-2:0], sclIn};
      sdaPipe <= {sdaPipe[PIPE_W-2:0], sdaIn};
    end
  end

  assign sclS    = sclPipe[SYNC_STAGES-1];
  assign sdaS    = sdaPipe[SYNC_STAGES-1];
  assign sclPrev = sclPipe[SYNC_STAGES];
  assign sdaPrev = sdaPipe[SYNC_STAGES];

  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startEv = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;

endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import cfgi2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startEv,
  input  logic      stopEv,
  input  logic      sdaS,
  input  logic [7:0] rxByte,
  input  logic      txBit,
  input  logic      wrAccept,
  output dpStrobe_t strb,
  output logic      sdaOeLow
);
  busState_t  state;
  logic [3:0] bitCnt;
  logic       isRead;
  logic       hostAck;

  always_comb begin
    strb = '0;
    if (startEv) begin
      strb.clrPtr = 1'b1;
    end else if (!stopEv) begin
      case (state)
        ST_ADDR: begin
          if (sclRise && bitCnt < 4'd8) strb.shiftIn = 1'b1;
        end
        ST_ADDR_ACK: begin
          if (sclFall && isRead) strb.loadTx = 1'b1;
        end
        ST_WR_BYTE: begin
          if (sclRise && bitCnt < 4'd8) strb.shiftIn = 1'b1;
          if (sclFall && bitCnt == 4'd8 && wrAccept) strb.commitByte = 1'b1;
        end
        ST_RD_BYTE: begin
          if (sclFall && bitCnt != 4'd7) strb.shiftTx = 1'b1;
        end
        ST_RD_ACK: begin
          if (sclFall && hostAck) strb.loadTx = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      isRead  <= 1'b0;
      hostAck <= 1'b0;
    end else if (startEv) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (stopEv) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise && bitCnt < 4'd8) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (rxByte[7:1] == DEV_ADDR) begin
              isRead <= rxByte[0];
              state  <= ST_ADDR_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            state  <= isRead ? ST_RD_BYTE : ST_WR_BYTE;
          end
        end
        ST_WR_BYTE: begin
          if (sclRise && bitCnt < 4'd8) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            state <= wrAccept ? ST_WR_ACK : ST_IDLE;
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            state  <= ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) state <= ST_RD_ACK;
            else bitCnt <= bitCnt + 4'd1;
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            hostAck <= ~sdaS;
          end else if (sclFall) begin
            bitCnt <= '0;
            state  <= hostAck ? ST_RD_BYTE : ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sdaOeLow = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                    ((state == ST_RD_BYTE) && !txBit);

endmodule

// File: rtl/cfg_reg_datapath.sv
module cfg_reg_datapath
  import cfgi2c_pkg::*;
#(
  parameter int NUM_BYTES = 7,
  parameter int PTR_W     = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strb,
  input  logic                   sdaS,
  input  logic                   strapIn,
  output logic [7:0]             rxByte,
  output logic                   txBit,
  output logic                   wrAccept,
  output logic [PTR_W-1:0]       ptr,
  output logic [NUM_BYTES*8-1:0] regView
);
  localparam int HDR_BYTES = 2;
  localparam int PTR_LAST  = NUM_BYTES + HDR_BYTES;

  logic [7:0] rxShift;
  logic [7:0] txShift;
  logic [7:0] txNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      ptr     <= '0;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[6:0], sdaS};
      if (strb.loadTx) txShift <= txNext;
      else if (strb.shiftTx) txShift <= {txShift[6:0], 1'b1};
      if (strb.clrPtr) ptr <= '0;
      else if ((strb.commitByte || strb.loadTx) && ptr != PTR_W'(PTR_LAST))
        ptr <= ptr + 1'b1;
    end
  end

  assign rxByte   = rxShift;
  assign txBit    = txShift[7];
  assign wrAccept = (ptr < PTR_W'(PTR_LAST));

  // read order: count first, then registers, then released bus
  always_comb begin
    txNext = 8'hFF;
    if (ptr == '0) txNext = 8'(NUM_BYTES);
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (ptr == PTR_W'(i + 1)) txNext = regView[i*8 +: 8];
    end
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : genByte
    localparam logic [7:0] WMASK = writableMask(g);
    logic [7:0] stored;
    logic       wrEn;

    assign wrEn = strb.commitByte && (ptr == PTR_W'(g + HDR_BYTES));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stored <= resetValue(g);
      else if (wrEn) stored <= (stored & ~WMASK) | (rxShift & WMASK);
    end

    if (g == STRAP_BYTE) begin : genStrap
      localparam logic [7:0] SBIT = 8'h1 << STRAP_BIT;
      assign regView[g*8 +: 8] = (stored & ~SBIT) | (strapIn ? SBIT : 8'h00);
    end else begin : genPlain
      assign regView[g*8 +: 8] = stored;
    end
  end

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import cfgi2c_pkg::*;
#(
  parameter int         NUM_BYTES   = 7,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  input  logic                   strapIn,
  output logic                   sdaOeLow,
  output logic [NUM_BYTES*8-1:0] cfgRegs
);
  localparam int PTR_W = $clog2(NUM_BYTES + 3);

  logic sclS, sdaS, sclRise, sclFall, startEv, stopEv;
  logic [7:0] rxByte;
  logic txBit, wrAccept;
  logic [PTR_W-1:0] ptr;
  dpStrobe_t strb;

  i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) uSampler (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  i2c_slave_ctrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .sdaS(sdaS), .rxByte(rxByte),
    .txBit(txBit), .wrAccept(wrAccept), .strb(strb), .sdaOeLow(sdaOeLow)
  );

  cfg_reg_datapath #(.NUM_BYTES(NUM_BYTES), .PTR_W(PTR_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaS(sdaS), .strapIn(strapIn),
    .rxByte(rxByte), .txBit(txBit), .wrAccept(wrAccept), .ptr(ptr),
    .regView(cfgRegs)
  );

endmodule

// File: rtl/cfgi2c_checker.sv
module cfgi2c_checker
  import cfgi2c_pkg::*;
#(
  parameter int NUM_BYTES = 7,
  parameter int PTR_W     = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_BYTES*8-1:0] cfgRegs,
  input logic                   sdaOeLow,
  input logic                   sclS,
  input logic                   startEv,
  input logic                   commitStb,
  input logic [PTR_W-1:0]       ptr
);
  localparam logic [NUM_BYTES*8-1:0] STRAP_MASK =
    (NUM_BYTES*8)'(1) << (STRAP_BYTE*8 + STRAP_BIT);

  function automatic logic [NUM_BYTES*8-1:0] defaultVec();
    logic [NUM_BYTES*8-1:0] v;
    for (int i = 0; i < NUM_BYTES; i++) v[i*8 +: 8] = resetValue(i);
    return v;
  endfunction

  localparam logic [NUM_BYTES*8-1:0] DEF_VEC = defaultVec();

  // R7: registers hold their defaults once reset has been seen
  a_r7_reset_defaults: assert property (@(posedge clk)
    !rstN |=> ((cfgRegs & ~STRAP_MASK) == (DEF_VEC & ~STRAP_MASK)));

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    cfgRegs[3] == 1'b0);

  // R3: register contents change only after a byte commit
  a_r3_change_needs_commit: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgRegs & ~STRAP_MASK) != $past(cfgRegs & ~STRAP_MASK)) |-> $past(commitStb));

  a_r9_start_clears_ptr: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> (ptr == '0));

  a_r5_ptr_bounded: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= PTR_W'(NUM_BYTES + 2));

  a_r10_sda_quiet_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS)) |-> $stable(sdaOeLow));

endmodule

bind i2c_cfg_slave cfgi2c_checker #(.NUM_BYTES(NUM_BYTES), .PTR_W(PTR_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgRegs(cfgRegs), .sdaOeLow(sdaOeLow),
  .sclS(sclS), .startEv(startEv), .commitStb(strb.commitByte), .ptr(ptr)
);

// File: tb/tb_i2c_cfg_slave.sv
module tb_i2c_cfg_slave;
  localparam int NB = 7;
  localparam int Q  = 10;
  localparam int H  = 20;

  // each row: number of data bytes, then up to 7 data bytes
  localparam logic [7:0] WVEC [0:3][0:7] = '{
    '{8'd7, 8'hA5, 8'h3C, 8'hFF, 8'h0F, 8'h81, 8'h7E, 8'hC3},
    '{8'd3, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'd0, 8'h77, 8'h77, 8'h77, 8'h77, 8'h77, 8'h77, 8'h77},
    '{8'd3, 8'h08, 8'hC1, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLine = 1'b1;
  logic sdaHost = 1'b1;
  logic strapIn = 1'b0;
  logic sdaOeLow;
  logic sdaIn;
  logic [NB*8-1:0] cfgRegs;

  int nChecks = 0;
  int nFail = 0;
  logic sdaGlitch = 1'b0;
  logic [7:0] model [0:NB-1];
  logic [7:0] txBuf [0:15];
  logic       ackBuf [0:15];
  logic [7:0] rdBuf [0:7];
  logic       rdAddrAck;

  assign sdaIn = sdaHost & ~sdaOeLow;

  always #2.5ns clk = ~clk;

  i2c_cfg_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaIn),
    .strapIn(strapIn), .sdaOeLow(sdaOeLow), .cfgRegs(cfgRegs)
  );

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] viewByte(input int i);
    if (i == 2) return (model[2] & 8'hFD) | (strapIn ? 8'h02 : 8'h00);
    return model[i];
  endfunction

  // R8: byte 0 bit 3 and byte 2 bit 1 are not writable
  function automatic void applyWrite(input int k, input logic [7:0] d);
    logic [7:0] m;
    m = (k == 0) ? 8'hF7 : (k == 2) ? 8'hFD : 8'hFF;
    model[k] = (model[k] & ~m) | (d & m);
  endfunction

  task automatic i2cStart();
    sdaHost = 1'b1; waitCyc(Q);
    sclLine = 1'b1; waitCyc(H);
    sdaHost = 1'b0; waitCyc(H);
    sclLine = 1'b0; waitCyc(Q);
  endtask

  task automatic i2cStop();
    sdaHost = 1'b0; waitCyc(Q);
    sclLine = 1'b1; waitCyc(H);
    sdaHost = 1'b1; waitCyc(H);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaHost = b[i]; waitCyc(Q);
      sclLine = 1'b1; waitCyc(H);
      sclLine = 1'b0; waitCyc(Q);
    end
  endtask

  task automatic writeByte(input logic [7:0] b, output logic acked);
    sendBits(b, 8);
    sdaHost = 1'b1; waitCyc(Q);
    sclLine = 1'b1; waitCyc(H/2);
    acked = (sdaIn == 1'b0);
    waitCyc(H/2);
    sclLine = 1'b0; waitCyc(Q);
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] b);
    logic s1;
    sdaHost = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitCyc(Q);
      sclLine = 1'b1; waitCyc(2);
      s1 = sdaIn;
      waitCyc(H - 2);
      b[i] = sdaIn;
      if (s1 !== b[i]) sdaGlitch = 1'b1;
      sclLine = 1'b0; waitCyc(Q);
    end
    sdaHost = ackIt ? 1'b0 : 1'b1; waitCyc(Q);
    sclLine = 1'b1; waitCyc(H);
    sclLine = 1'b0; waitCyc(2);
    sdaHost = 1'b1; waitCyc(Q - 2);
  endtask

  task automatic writeTx(input int n);
    logic a;
    i2cStart();
    writeByte(8'hD2, a);
    ackBuf[15] = a;
    for (int i = 0; i < n; i++) begin
      writeByte(txBuf[i], a);
      ackBuf[i] = a;
    end
    i2cStop();
  endtask

  task automatic readAll();
    logic a;
    i2cStart();
    writeByte(8'hD3, a);
    rdAddrAck = a;
    for (int i = 0; i < 8; i++) readByte(i != 7, rdBuf[i]);
    i2cStop();
  endtask

  task automatic checkRegs(input string req);
    for (int i = 0; i < NB; i++) check(req, {24'h0, cfgRegs[i*8 +: 8]}, {24'h0, viewByte(i)});
  endtask

  task automatic checkReadBack(input string req);
    readAll();
    check({req, " R1 read address ack"}, {31'h0, rdAddrAck}, 32'h1);
    check({req, " R6 byte count"}, {24'h0, rdBuf[0]}, 32'd7);
    for (int i = 0; i < NB; i++) check({req, " R6 read data"}, {24'h0, rdBuf[i+1]}, {24'h0, viewByte(i)});
    check({req, " R6 bus released after NACK"}, {31'h0, sdaOeLow}, 32'h0);
  endtask

  initial begin
    logic a;
    model[0] = 8'h00; model[1] = 8'hFE; model[2] = 8'hFE; model[3] = 8'hFE;
    model[4] = 8'h00; model[5] = 8'h00; model[6] = 8'h06;

    waitCyc(10);
    rstN = 1'b1;
    waitCyc(5);
    // R7 and R11: defaults on the parallel bus
    checkRegs("R7 R11 reset value");
    check("R7 SDA released after reset", {31'h0, sdaOeLow}, 32'h0);

    // table of block writes, each followed by a read-back
    for (int v = 0; v < 4; v++) begin
      int len;
      len = int'(WVEC[v][0]);
      txBuf[0] = 8'hC0 | 8'(v);
      txBuf[1] = 8'h07;
      for (int k = 0; k < len; k++) txBuf[k+2] = WVEC[v][k+1];
      writeTx(len + 2);
      check("R1 write address ack", {31'h0, ackBuf[15]}, 32'h1);
      check("R2 command byte ack", {31'h0, ackBuf[0]}, 32'h1);
      check("R2 count byte ack", {31'h0, ackBuf[1]}, 32'h1);
      for (int k = 0; k < len; k++) begin
        check("R3 data byte ack", {31'h0, ackBuf[k+2]}, 32'h1);
        applyWrite(k, WVEC[v][k+1]);
      end
      checkRegs("R3 R4 R2 R8 stored after block write");
      checkReadBack("table");
    end

    // R1: foreign address is ignored
    i2cStart();
    writeByte(8'hA0, a);
    check("R1 foreign address not acked", {31'h0, a}, 32'h0);
    writeByte(8'h00, a);
    check("R1 no ack after foreign address", {31'h0, a}, 32'h0);
    writeByte(8'h5B, a);
    i2cStop();
    checkRegs("R1 registers untouched by foreign address");

    // R5: byte past register 6 is refused
    txBuf[0] = 8'h00; txBuf[1] = 8'h07;
    for (int k = 0; k < NB; k++) txBuf[k+2] = 8'h10 + 8'(k);
    txBuf[9] = 8'h99;
    writeTx(10);
    for (int k = 0; k < NB; k++) applyWrite(k, 8'h10 + 8'(k));
    check("R5 last register acked", {31'h0, ackBuf[8]}, 32'h1);
    check("R5 extra byte not acked", {31'h0, ackBuf[9]}, 32'h0);
    checkRegs("R5 extra byte not stored");

    // R4: STOP inside a byte keeps earlier bytes, drops the partial one
    i2cStart();
    writeByte(8'hD2, a);
    writeByte(8'h00, a);
    writeByte(8'h07, a);
    writeByte(8'h5A, a);
    applyWrite(0, 8'h5A);
    sendBits(8'hE1, 3);
    i2cStop();
    checkRegs("R4 partial byte dropped");

    // R9: repeated START restarts at the command byte
    i2cStart();
    writeByte(8'hD2, a);
    writeByte(8'h00, a);
    writeByte(8'h07, a);
    writeByte(8'h11, a);
    i2cStart();
    writeByte(8'hD2, a);
    check("R9 address acked after repeated start", {31'h0, a}, 32'h1);
    writeByte(8'h00, a);
    writeByte(8'h07, a);
    writeByte(8'h22, a);
    i2cStop();
    applyWrite(0, 8'h22);
    checkRegs("R9 pointer restarted");

    // R8: strap bit follows the pin, ignores writes
    strapIn = 1'b1;
    waitCyc(4);
    check("R8 strap visible", {31'h0, cfgRegs[17]}, 32'h1);
    txBuf[0] = 8'h00; txBuf[1] = 8'h07;
    txBuf[2] = 8'hFF; txBuf[3] = 8'h00; txBuf[4] = 8'h00;
    writeTx(5);
    applyWrite(0, 8'hFF); applyWrite(1, 8'h00); applyWrite(2, 8'h00);
    check("R8 reserved bit stays zero", {31'h0, cfgRegs[3]}, 32'h0);
    check("R8 strap bit not written", {31'h0, cfgRegs[17]}, 32'h1);
    checkReadBack("R8 strap");
    strapIn = 1'b0;
    waitCyc(4);
    check("R8 strap follows pin low", {31'h0, cfgRegs[17]}, 32'h0);

    check("R10 SDA stable while SCL high", {31'h0, sdaGlitch}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule